// File: doc/BRIEF.md
# Chained Hash Table Probe Engine

The engine takes a stream of probe tuples, each carrying a join key, a probe tuple pointer and a bucket index that a hash unit elsewhere has already computed. For every accepted tuple it reads the bucket head from memory. An all-ones head marks an empty bucket, and the tuple is discarded at that point. Any other head turns the tuple into a job that walks the bucket chain one node at a time. Every node returns a key, a build tuple pointer and a next pointer. When the node key equals the probe key, the engine emits the probe pointer paired with the build pointer.

Jobs keep circulating inside the engine until their chain ends. A job first waits in a queue of new jobs. After each node fetch it moves to a queue of recycled jobs, unless its chain has finished. An arbiter feeds node fetches and always serves the recycled queue first. The node fetches are spread over two in-order read channels that take turns. A small tag queue records which channel each fetch went to, so the responses are consumed in the order the fetches were issued. The engine only reads memory. In unique-key mode, a job stops as soon as it finds its first match.

Top module: `hjp_probe_engine`

## Requirements
- R1: After reset no head read and no node fetch is requested, match_valid is low, probe_ready is high, done is low while keys_end is low, and no node response is accepted.
- R2: A head read (head_req high, head_addr equal to probe_bucket) is issued in exactly the cycles where probe_valid and probe_ready are both high.
- R3: A head response equal to all ones drops the probe tuple: it causes no node fetch and no match.
- R4: probe_ready is low whenever the new-job queue occupancy plus outstanding head reads equals NEW_DEPTH. With default depth 4 and no head responses returning, exactly 4 tuples are accepted.
- R5: No job leaves the new-job queue while the recycled queue holds a job. Chains longer than the queue depths still drain completely.
- R6: match_valid rises in the cycle after a node response is accepted whose key equals the job's probe key. It carries that job's probe pointer and that node's build pointer, and no other matches appear.
- R7: A node whose next pointer is not all ones causes a later fetch at that next pointer. A next pointer of all ones ends the job. Each job fetches exactly the nodes of its chain.
- R8: With uniq_mode high, a job ends at its first matching node. It fetches no further nodes and yields one match at most.
- R9: Node fetches alternate between channels, starting with channel 0 (node_req one-hot, bit 0 then bit 1). node_rsp_ready is high only for the channel of the oldest outstanding fetch.
- R10: done is high exactly when keys_end is high and no head read, queued job or node fetch remains. By then every match has been emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uniq_mode | input | 1 | Build keys are unique; stop a job at its first match |
| keys_end | input | 1 | No further probe tuples will be offered |
| probe_valid | input | 1 | Probe tuple offered |
| probe_ready | output | 1 | Probe tuple accepted when valid is also high |
| probe_key | input | KEY_W | Join key of the probe tuple |
| probe_ptr | input | PTR_W | Probe tuple pointer |
| probe_bucket | input | PTR_W | Hashed bucket index |
| head_req | output | 1 | Bucket-head read request |
| head_addr | output | PTR_W | Bucket index to read |
| head_rsp_valid | input | 1 | Bucket-head read data valid (in order) |
| head_rsp_ptr | input | PTR_W | Head node pointer, all ones when empty |
| node_req | output | NCH | Node fetch request, one bit per channel |
| node_addr | output | PTR_W | Node pointer to fetch |
| node_rsp_valid | input | NCH | Node response valid per channel |
| node_rsp_ready | output | NCH | Node response taken per channel |
| node_rsp_key | input | NCH x KEY_W | Node key per channel |
| node_rsp_bptr | input | NCH x PTR_W | Node build tuple pointer per channel |
| node_rsp_next | input | NCH x PTR_W | Next node pointer, all ones at chain end |
| match_valid | output | 1 | Joined pair present |
| match_probe_ptr | output | PTR_W | Probe tuple pointer of the pair |
| match_build_ptr | output | PTR_W | Build tuple pointer of the pair |
| done | output | 1 | All work finished after keys_end |

## Verification
Several functions can fall in the same cycle. A node response can end a job or recycle it while the arbiter is pulling a different recycled job for the next fetch. A head response can also push into the new-job queue in the very cycle that queue is drained. The bench provokes these overlaps by giving the two node channels independent random latencies, by inserting gaps in the probe stream, and by using chains longer than the queue depths. Its behavioural memory and chain-walk model judges every clock: match pairs are drawn from a precomputed multiset, and the channel order and the response-ready lane are checked against its own list of outstanding fetches. Each phase also ends with a comparison of total fetches and leftover matches.

// File: rtl/hjp_pkg.sv
package hjp_pkg;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_REC  = 2'd1,
        PICK_NEW  = 2'd2
    } pick_e;

endpackage

// File: rtl/hjp_fifo.sv
module hjp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hjp_arbiter.sv
module hjp_arbiter
    import hjp_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rec_avail,
    input  logic           new_avail,
    input  logic           new_credit,
    input  logic           slot_free,
    output pick_e          pick,
    output logic [CHW-1:0] ch
);
    typedef struct packed {
        logic [CHW-1:0] ch;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        pick = PICK_NONE;
        if (slot_free) begin
            if (rec_avail)                    pick = PICK_REC;
            else if (new_avail && new_credit) pick = PICK_NEW;
        end
        st_d = st_q;
        if (pick != PICK_NONE) begin
            st_d.ch = (st_q.ch == CHW'(NCH - 1)) ? '0 : st_q.ch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch = st_q.ch;

endmodule

// File: rtl/hjp_probe_engine.sv
module hjp_probe_engine
    import hjp_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int PTR_W     = 8,
    parameter int NEW_DEPTH = 4,
    parameter int REC_DEPTH = 4,
    parameter int NCH       = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       uniq_mode,
    input  logic                       keys_end,
    input  logic                       probe_valid,
    output logic                       probe_ready,
    input  logic [KEY_W-1:0]           probe_key,
    input  logic [PTR_W-1:0]           probe_ptr,
    input  logic [PTR_W-1:0]           probe_bucket,
    output logic                       head_req,
    output logic [PTR_W-1:0]           head_addr,
    input  logic                       head_rsp_valid,
    input  logic [PTR_W-1:0]           head_rsp_ptr,
    output logic [NCH-1:0]             node_req,
    output logic [PTR_W-1:0]           node_addr,
    input  logic [NCH-1:0]             node_rsp_valid,
    output logic [NCH-1:0]             node_rsp_ready,
    input  logic [NCH-1:0][KEY_W-1:0]  node_rsp_key,
    input  logic [NCH-1:0][PTR_W-1:0]  node_rsp_bptr,
    input  logic [NCH-1:0][PTR_W-1:0]  node_rsp_next,
    output logic                       match_valid,
    output logic [PTR_W-1:0]           match_probe_ptr,
    output logic [PTR_W-1:0]           match_build_ptr,
    output logic                       done
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int NCW = $clog2(NEW_DEPTH + 1);
    localparam int RCW = $clog2(REC_DEPTH + 1);
    localparam logic [PTR_W-1:0] NIL = '1;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [PTR_W-1:0] pptr;
    } probe_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [PTR_W-1:0] pptr;
        logic [PTR_W-1:0] cur;
    } job_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [PTR_W-1:0] pptr;
        logic [CHW-1:0]   ch;
    } flight_t;

    typedef struct packed {
        logic             hit;
        logic [PTR_W-1:0] pp;
        logic [PTR_W-1:0] bp;
    } out_st_t;

    // head-read tracking queue
    probe_t     hq_din, hq_head;
    logic [NCW-1:0] hq_cnt;
    logic       hq_empty, hq_full, hq_push, hq_pop;

    // new-job queue
    job_t       nq_din, nq_head;
    logic [NCW-1:0] nq_cnt;
    logic       nq_empty, nq_full, nq_push, nq_pop;

    // recycled-job queue
    job_t       rq_din, rq_head;
    logic [RCW-1:0] rq_cnt;
    logic       rq_empty, rq_full, rq_push, rq_pop;

    // node fetches in flight, in issue order
    flight_t    fl_din, fl_head;
    logic [RCW-1:0] fl_cnt;
    logic       fl_empty, fl_full, fl_push, fl_pop;

    pick_e          pick;
    logic [CHW-1:0] arb_ch;
    logic           issue;
    job_t           job_sel;

    logic             rsp_take, hit, job_end;
    logic [KEY_W-1:0] sel_key;
    logic [PTR_W-1:0] sel_bptr, sel_next;

    out_st_t out_d, out_q;

    // ---------------- head reads ----------------
    assign probe_ready = !hq_full
                      && ((int'(hq_cnt) + int'(nq_cnt)) < NEW_DEPTH);
    assign hq_push   = probe_valid && probe_ready;
    assign head_req  = hq_push;
    assign head_addr = probe_bucket;
    assign hq_din    = '{key: probe_key, pptr: probe_ptr};
    assign hq_pop    = head_rsp_valid;

    hjp_fifo #(.W($bits(probe_t)), .DEPTH(NEW_DEPTH), .CW(NCW)) u_hq (
        .clk(clk), .rst_n(rst_n),
        .push(hq_push), .din(hq_din), .pop(hq_pop), .dout(hq_head),
        .count(hq_cnt), .empty(hq_empty), .full(hq_full)
    );

    assign nq_push = head_rsp_valid && (head_rsp_ptr != NIL);
    assign nq_din  = '{key: hq_head.key, pptr: hq_head.pptr, cur: head_rsp_ptr};

    hjp_fifo #(.W($bits(job_t)), .DEPTH(NEW_DEPTH), .CW(NCW)) u_nq (
        .clk(clk), .rst_n(rst_n),
        .push(nq_push), .din(nq_din), .pop(nq_pop), .dout(nq_head),
        .count(nq_cnt), .empty(nq_empty), .full(nq_full)
    );

    // ---------------- job arbitration ----------------
    hjp_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .rec_avail(!rq_empty),
        .new_avail(!nq_empty),
        .new_credit((int'(rq_cnt) + int'(fl_cnt)) < REC_DEPTH),
        .slot_free(!fl_full),
        .pick(pick),
        .ch(arb_ch)
    );

    assign rq_pop  = (pick == PICK_REC);
    assign nq_pop  = (pick == PICK_NEW);
    assign issue   = rq_pop || nq_pop;
    assign job_sel = rq_pop ? rq_head : nq_head;
    assign node_addr = job_sel.cur;

    assign fl_push = issue;
    assign fl_din  = '{key: job_sel.key, pptr: job_sel.pptr, ch: arb_ch};

    hjp_fifo #(.W($bits(flight_t)), .DEPTH(REC_DEPTH), .CW(RCW)) u_fl (
        .clk(clk), .rst_n(rst_n),
        .push(fl_push), .din(fl_din), .pop(fl_pop), .dout(fl_head),
        .count(fl_cnt), .empty(fl_empty), .full(fl_full)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign node_req[c]       = issue && (arb_ch == CHW'(c));
        assign node_rsp_ready[c] = !fl_empty && (fl_head.ch == CHW'(c));
    end

    // ---------------- node responses ----------------
    assign sel_key  = node_rsp_key[fl_head.ch];
    assign sel_bptr = node_rsp_bptr[fl_head.ch];
    assign sel_next = node_rsp_next[fl_head.ch];
    assign rsp_take = !fl_empty && node_rsp_valid[fl_head.ch];
    assign fl_pop   = rsp_take;
    assign hit      = rsp_take && (sel_key == fl_head.key);
    assign job_end  = (sel_next == NIL) || (uniq_mode && hit);

    assign rq_push = rsp_take && !job_end;
    assign rq_din  = '{key: fl_head.key, pptr: fl_head.pptr, cur: sel_next};

    hjp_fifo #(.W($bits(job_t)), .DEPTH(REC_DEPTH), .CW(RCW)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(rq_push), .din(rq_din), .pop(rq_pop), .dout(rq_head),
        .count(rq_cnt), .empty(rq_empty), .full(rq_full)
    );

    // ---------------- match output ----------------
    always_comb begin
        out_d     = out_q;
        out_d.hit = hit;
        if (hit) begin
            out_d.pp = fl_head.pptr;
            out_d.bp = sel_bptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign match_valid     = out_q.hit;
    assign match_probe_ptr = out_q.pp;
    assign match_build_ptr = out_q.bp;

    assign done = keys_end && hq_empty && nq_empty && rq_empty && fl_empty;

    // ---------------- checks ----------------
    logic [NCH-1:0] last_req_q;
    logic           seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_req_q <= '0;
            seen_q     <= 1'b0;
        end else if (|node_req) begin
            last_req_q <= node_req;
            seen_q     <= 1'b1;
        end
    end

    // R3
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_rsp_valid && head_rsp_ptr == NIL && !nq_pop) |=> (nq_cnt == $past(nq_cnt)));

    // R4
    new_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nq_push |-> !nq_full);

    // R5
    rec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nq_pop |-> rq_empty);

    // R5
    rec_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_push |-> !rq_full);

    // R6
    match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(|(node_rsp_valid & node_rsp_ready)));

    // R9
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(node_req) && $onehot0(node_rsp_ready));

    // R9
    alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|node_req && seen_q) |-> (node_req != last_req_q));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (node_req == '0 && node_rsp_ready == '0));

endmodule

// File: tb/hjp_probe_engine_tb.sv
`timescale 1ns/1ps
module hjp_probe_engine_tb;
    localparam int KW = 16;
    localparam int PW = 8;
    localparam int ND = 4;
    localparam int RD = 4;
    localparam int NC = 2;
    localparam int NIL = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uniq_mode = 1'b0;
    logic keys_end = 1'b0;
    logic probe_valid = 1'b0;
    logic probe_ready;
    logic [KW-1:0] probe_key = '0;
    logic [PW-1:0] probe_ptr = '0;
    logic [PW-1:0] probe_bucket = '0;
    logic head_req;
    logic [PW-1:0] head_addr;
    logic head_rsp_valid = 1'b0;
    logic [PW-1:0] head_rsp_ptr = '0;
    logic [NC-1:0] node_req;
    logic [PW-1:0] node_addr;
    logic [NC-1:0] node_rsp_valid = '0;
    logic [NC-1:0] node_rsp_ready;
    logic [NC-1:0][KW-1:0] node_rsp_key = '0;
    logic [NC-1:0][PW-1:0] node_rsp_bptr = '0;
    logic [NC-1:0][PW-1:0] node_rsp_next = '0;
    logic match_valid;
    logic [PW-1:0] match_probe_ptr, match_build_ptr;
    logic done;

    always #2.5 clk = ~clk;

    hjp_probe_engine #(.KEY_W(KW), .PTR_W(PW), .NEW_DEPTH(ND), .REC_DEPTH(RD), .NCH(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .uniq_mode(uniq_mode), .keys_end(keys_end),
        .probe_valid(probe_valid), .probe_ready(probe_ready), .probe_key(probe_key),
        .probe_ptr(probe_ptr), .probe_bucket(probe_bucket),
        .head_req(head_req), .head_addr(head_addr),
        .head_rsp_valid(head_rsp_valid), .head_rsp_ptr(head_rsp_ptr),
        .node_req(node_req), .node_addr(node_addr),
        .node_rsp_valid(node_rsp_valid), .node_rsp_ready(node_rsp_ready),
        .node_rsp_key(node_rsp_key), .node_rsp_bptr(node_rsp_bptr), .node_rsp_next(node_rsp_next),
        .match_valid(match_valid), .match_probe_ptr(match_probe_ptr),
        .match_build_ptr(match_build_ptr), .done(done)
    );

    int total = 0;
    int bad = 0;

    // memory image
    int h_tab [256];
    int n_key [256];
    int n_bp  [256];
    int n_nx  [256];
    int n_alloc;

    // probe stream
    int pq_key[$];
    int pq_ptr[$];
    int pq_bkt[$];

    // expectations
    int exp_q[$];
    int exp_fetch;

    // memory response queues
    int hd_due[$];
    int hd_val[$];
    int nd_due[NC][$];
    int nd_addr[NC][$];
    int ord_ch[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            h_tab[i] = NIL; n_key[i] = 0; n_bp[i] = 0; n_nx[i] = NIL;
        end
        n_alloc = 0;
        pq_key.delete(); pq_ptr.delete(); pq_bkt.delete();
    endtask

    task automatic add_node(input int b, input int k);
        n_key[n_alloc] = k;
        n_bp[n_alloc]  = (n_alloc * 7 + 3) % 250;
        n_nx[n_alloc]  = h_tab[b];
        h_tab[b]       = n_alloc;
        n_alloc++;
    endtask

    task automatic add_probe(input int k, input int b);
        pq_key.push_back(k);
        pq_ptr.push_back(pq_key.size());
        pq_bkt.push_back(b);
    endtask

    task automatic compute_exp(input bit uq);
        exp_q.delete();
        exp_fetch = 0;
        foreach (pq_key[i]) begin
            int p;
            p = h_tab[pq_bkt[i]];
            while (p != NIL) begin
                exp_fetch++;
                if (n_key[p] == pq_key[i]) begin
                    exp_q.push_back(pq_ptr[i] * 256 + n_bp[p]);
                    if (uq) break;
                end
                p = n_nx[p];
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        probe_valid = 1'b0; keys_end = 1'b0;
        head_rsp_valid = 1'b0; node_rsp_valid = '0;
        hd_due.delete(); hd_val.delete(); ord_ch.delete();
        for (int c = 0; c < NC; c++) begin
            nd_due[c].delete(); nd_addr[c].delete();
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(node_req == '0 && !head_req, "R1", "requests after reset", node_req, 0);
        chk(!match_valid, "R1", "match_valid after reset", match_valid, 0);
        chk(probe_ready && !done, "R1", "ready/done after reset", {probe_ready, done}, 2);
        chk(node_rsp_ready == '0, "R1", "rsp ready after reset", node_rsp_ready, 0);
    endtask

    task automatic run_phase(input string tag, input bit uq, input int hlat,
                             input int nlo, input int nhi, input int gap,
                             input bit cap_chk);
        int cyc = 0;
        bit done_seen = 0;
        bit s_hs = 0, s_hreq = 0, s_hacc = 0, prev_acc = 0;
        int s_haddr = 0, s_naddr = 0, prev_bp = 0;
        bit [NC-1:0] s_req = '0, s_acc = '0;
        int exp_ch = 0;
        int fetches = 0;
        int hs_cnt = 0;
        int early_done = 0;

        uniq_mode = uq;
        compute_exp(uq);
        do_reset();
        while (!done_seen && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            // retire what fired at the last edge
            if (s_hs) begin
                pq_key.pop_front(); pq_ptr.pop_front(); pq_bkt.pop_front();
                hs_cnt++;
            end
            if (s_hacc) begin
                void'(hd_due.pop_front()); void'(hd_val.pop_front());
            end
            if (s_hreq) begin
                hd_due.push_back(cyc - 1 + hlat);
                hd_val.push_back(h_tab[s_haddr]);
            end
            for (int c = 0; c < NC; c++) begin
                if (s_acc[c]) begin
                    void'(nd_due[c].pop_front()); void'(nd_addr[c].pop_front());
                    void'(ord_ch.pop_front());
                end
            end
            for (int c = 0; c < NC; c++) begin
                if (s_req[c]) begin
                    nd_due[c].push_back(cyc + $urandom_range(nhi, nlo));
                    nd_addr[c].push_back(s_naddr);
                    ord_ch.push_back(c);
                    fetches++;
                end
            end
            // match output from the last edge
            if (match_valid) begin
                int code;
                int idx;
                code = int'(match_probe_ptr) * 256 + int'(match_build_ptr);
                idx = -1;
                foreach (exp_q[i]) if (idx < 0 && exp_q[i] == code) idx = i;
                chk(prev_acc && int'(match_build_ptr) == prev_bp, "R6",
                    "match timing/build ptr", match_build_ptr, prev_bp);
                chk(idx >= 0, "R6", {tag, " match pair expected"}, code, -1);
                if (idx >= 0) exp_q.delete(idx);
            end
            // drive inputs
            if (pq_key.size() > 0 && $urandom_range(99, 0) >= gap) begin
                probe_valid  = 1'b1;
                probe_key    = KW'(pq_key[0]);
                probe_ptr    = PW'(pq_ptr[0]);
                probe_bucket = PW'(pq_bkt[0]);
            end else begin
                probe_valid = 1'b0;
            end
            keys_end = (pq_key.size() == 0);
            head_rsp_valid = (hd_due.size() > 0) && (hd_due[0] <= cyc);
            head_rsp_ptr   = (hd_val.size() > 0) ? PW'(hd_val[0]) : '0;
            for (int c = 0; c < NC; c++) begin
                if (nd_due[c].size() > 0 && nd_due[c][0] <= cyc) begin
                    node_rsp_valid[c] = 1'b1;
                    node_rsp_key[c]   = KW'(n_key[nd_addr[c][0]]);
                    node_rsp_bptr[c]  = PW'(n_bp[nd_addr[c][0]]);
                    node_rsp_next[c]  = PW'(n_nx[nd_addr[c][0]]);
                end else begin
                    node_rsp_valid[c] = 1'b0;
                end
            end
            #1;
            // sample what will fire at the next edge
            s_hs = probe_valid && probe_ready;
            if (head_req != s_hs) chk(0, "R2", "head_req vs handshake", head_req, s_hs);
            if (s_hs) chk(int'(head_addr) == pq_bkt[0], "R2", "head_addr", head_addr, pq_bkt[0]);
            s_hreq = head_req;
            s_haddr = int'(head_addr);
            s_hacc = head_rsp_valid;
            s_req = node_req;
            s_naddr = int'(node_addr);
            if (node_req != '0) begin
                chk(node_req == NC'(1 << exp_ch), "R9", "channel order", node_req, 1 << exp_ch);
                exp_ch = (exp_ch + 1) % NC;
            end
            if (ord_ch.size() > 0)
                chk(node_rsp_ready == NC'(1 << ord_ch[0]), "R9", "response lane",
                    node_rsp_ready, 1 << ord_ch[0]);
            else if (node_rsp_ready != '0)
                chk(0, "R9", "ready with nothing outstanding", node_rsp_ready, 0);
            s_acc = node_rsp_valid & node_rsp_ready;
            prev_acc = (s_acc != '0);
            prev_bp = s_acc[1] ? int'(node_rsp_bptr[1]) : int'(node_rsp_bptr[0]);
            if (!keys_end && done) early_done++;
            if (cap_chk && cyc == 14) begin
                chk(hs_cnt + int'(s_hs) == ND, "R4", "accepted with heads stalled", hs_cnt + s_hs, ND);
                chk(!probe_ready, "R4", "probe_ready at capacity", probe_ready, 0);
            end
            if (done) done_seen = 1;
        end
        chk(done_seen, "R10", {tag, " done reached"}, done_seen, 1);
        chk(early_done == 0, "R10", {tag, " done before keys_end"}, early_done, 0);
        chk(exp_q.size() == 0, "R7", {tag, " matches left unemitted"}, exp_q.size(), 0);
        chk(fetches == exp_fetch, uq ? "R8" : "R7", {tag, " node fetch count"}, fetches, exp_fetch);
        chk(ord_ch.size() == 0 && hd_due.size() == 0, "R10", {tag, " nothing outstanding at done"},
            ord_ch.size() + hd_due.size(), 0);
    endtask

    initial begin
        // phase 1: mixed hits, misses and empty buckets (R3, R6, R7)
        clear_mem();
        add_node(1, 5);
        add_node(2, 7); add_node(2, 9); add_node(2, 7);
        add_node(3, 11); add_node(3, 12);
        add_node(4, 20);
        add_probe(5, 1);  add_probe(7, 2);  add_probe(9, 2);  add_probe(8, 2);
        add_probe(3, 0);  add_probe(11, 3); add_probe(12, 3); add_probe(4, 0);
        add_probe(20, 4); add_probe(7, 2);  add_probe(99, 5); add_probe(5, 1);
        run_phase("basic R3", 1'b0, 2, 1, 3, 0, 1'b0);

        // phase 2: head reads stalled, admission capacity (R4)
        clear_mem();
        add_node(1, 5); add_node(2, 6); add_node(2, 6);
        for (int i = 0; i < 6; i++) add_probe((i % 2 == 0) ? 5 : 6, (i % 2 == 0) ? 1 : 2);
        run_phase("stall", 1'b0, 40, 1, 2, 0, 1'b1);

        // phase 3: long chains, random latency and gaps (R5)
        clear_mem();
        for (int b = 10; b < 15; b++)
            for (int i = 0; i < 6; i++) add_node(b, b * 8 + (i % 4));
        for (int i = 0; i < 20; i++) begin
            int b;
            b = 10 + (i % 6);
            add_probe(b * 8 + int'($urandom_range(4, 0)), b);
        end
        run_phase("R5 long chains", 1'b0, 3, 1, 7, 30, 1'b0);

        // phase 4: unique-key mode stops at first hit (R8)
        clear_mem();
        add_node(2, 7); add_node(2, 7); add_node(2, 7);
        add_node(3, 1); add_node(3, 2); add_node(3, 1);
        add_probe(7, 2); add_probe(1, 3); add_probe(2, 3); add_probe(4, 3); add_probe(7, 1);
        run_phase("R8 unique", 1'b1, 2, 1, 4, 10, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule